// File: doc/BRIEF.md
# Transactional Conflict List Tracker

This block sits beside one core of a chip multiprocessor that runs hardware transactions. Conflicts are detected eagerly: while a transaction runs, the coherence side tells the block each time a remote core touches a line that this core also holds speculatively. Resolution is lazy: the block only records who conflicts with whom, in two per-core bit vectors. The racer vector lists the cores this transaction will abort if it commits first. The killer vector lists the cores that may abort it.

At commit the block sends an abort message to each recorded racer, one per cycle and lowest core first. It then waits for an acknowledge from each of them before it signals commit done. A transaction with no racers commits without any message, so transactions that touch disjoint data commit in parallel. If an abort from another core arrives before this core has reached its commit point, the block drops the transaction, pulses a checkpoint restore and acknowledges the sender. Once the commit sequence has started, incoming aborts are only acknowledged, because the first transaction to commit wins.

Each tracked line has one speculative-read marker and one speculative-modified marker. These markers, and both vectors, are cleared together when a transaction begins, when a commit completes and when a transaction aborts. Both vectors are brought out so that the core's contention logic can see them.

Top module: `txn_conflict_tracker`

## Requirements
- R1: A begin request in the idle state starts a transaction. A commit request outside a transaction is ignored and produces neither an abort message nor commit done.
- R2: A conflict notification in which neither this core nor the remote core wrote the line (this line read only, remote access a read, `cfl_write_i`=0) leaves both vectors unchanged.
- R3: If the notified line is marked modified locally, the remote core's bit is set in the racer vector, whether the remote access was a read or a write.
- R4: If the notified line is marked read or modified locally and the remote access is a write (`cfl_write_i`=1), the remote core's bit is set in the killer vector.
- R5: Local read and write events set the read and modified markers of the given line index. A notification for a line that carries neither marker changes no vector.
- R6: On commit, the block sends one abort message per cycle, starting in the cycle after the commit request. The messages go to exactly the cores set in the racer vector, in ascending core order, and the vectors stay unchanged while they are sent.
- R7: Commit done is asserted for one cycle, only after an acknowledge has arrived from every targeted core. With an empty racer vector, it comes in the cycle after the commit request and no abort message is sent.
- R8: An abort received during a running transaction (before commit) gives, in the next cycle, a checkpoint restore pulse together with an acknowledge addressed to the sender. The transaction ends and both vectors read zero.
- R9: An abort received while idle or during the commit sequence is acknowledged in the next cycle without a restore, and the commit sequence continues.
- R10: A conflict notification that names this block's own core ID, or that arrives outside a running transaction, is ignored.
- R11: Markers and both vectors are cleared on begin, on commit completion and on abort.
- R12: An abort arriving in the same cycle as a commit request takes priority (the transaction aborts). A conflict notification in the same cycle as a commit request is included in the set of cores to abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin_i | input | 1 | Local transaction begin request |
| tx_commit_i | input | 1 | Local commit request |
| acc_valid_i | input | 1 | Local speculative access event |
| acc_write_i | input | 1 | 1 = local write, 0 = local read |
| acc_line_i | input | LIDX_W | Line index of the local access |
| cfl_valid_i | input | 1 | Conflict notification valid |
| cfl_core_i | input | CID_W | Remote core ID of the notification |
| cfl_write_i | input | 1 | 1 = remote write, 0 = remote read |
| cfl_line_i | input | LIDX_W | Line index of the notification |
| abt_valid_i | input | 1 | Incoming abort message |
| abt_src_i | input | CID_W | Core that sent the abort |
| abt_ack_valid_i | input | 1 | Incoming abort acknowledge |
| abt_ack_src_i | input | CID_W | Core that acknowledged |
| abt_valid_o | output | 1 | Outgoing abort message |
| abt_dst_o | output | CID_W | Core addressed by the abort |
| abt_ack_valid_o | output | 1 | Outgoing abort acknowledge |
| abt_ack_dst_o | output | CID_W | Core addressed by the acknowledge |
| ckpt_restore_o | output | 1 | Register checkpoint restore pulse |
| commit_done_o | output | 1 | Commit completed pulse |
| racers_o | output | NUM_CORES | Cores to abort at commit |
| killers_o | output | NUM_CORES | Cores that may abort this transaction |

## Verification
A wrong marker or vector bit is visible on `racers_o` or `killers_o` in the cycle after the notification that set it. It also changes the abort messages sent at the next commit, both in their destinations and in how many cycles they take. A lost acknowledge or a stale wait bit holds commit done back indefinitely. A mishandled incoming abort shows as a missing or extra restore pulse one cycle later. The bench replays every cycle through its own model, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/tct_pkg.sv
package tct_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_COMMIT = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic set_racer;
    logic set_killer;
  } cfl_action_t;

  // Decide which vector a notification touches, from the local markers of
  // the line and the kind of remote access.
  function automatic cfl_action_t classify(input logic loc_rd, input logic loc_md,
                                           input logic rem_wr);
    cfl_action_t a;
    a.set_racer  = loc_md;
    a.set_killer = rem_wr & (loc_rd | loc_md);
    return a;
  endfunction

  // Index of the lowest set bit (0 when the vector is empty).
  function automatic int unsigned lowest_index(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/tct_line_sets.sv
module tct_line_sets #(
  parameter int NUM_LINES = 16,
  localparam int LIDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 set_en_i,
  input  logic                 set_write_i,
  input  logic [LIDX_W-1:0]    set_line_i,
  input  logic [LIDX_W-1:0]    look_line_i,
  output logic                 look_rd_o,
  output logic                 look_md_o
);

  logic [NUM_LINES-1:0] rd_q;
  logic [NUM_LINES-1:0] md_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit;
    assign hit = set_en_i && (set_line_i == LIDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
        rd_q[g] <= 1'b0;
        md_q[g] <= 1'b0;
      end else if (hit) begin
        if (set_write_i) md_q[g] <= 1'b1;
        else             rd_q[g] <= 1'b1;
      end
    end
  end

  assign look_rd_o = rd_q[look_line_i];
  assign look_md_o = md_q[look_line_i];

endmodule

// File: rtl/tct_conflict_vec.sv
module tct_conflict_vec
  import tct_pkg::*;
#(
  parameter int NUM_CORES = 8,
  localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 en_i,
  input  logic [CID_W-1:0]     core_i,
  input  logic                 rem_wr_i,
  input  logic                 loc_rd_i,
  input  logic                 loc_md_i,
  output logic [NUM_CORES-1:0] racers_o,
  output logic [NUM_CORES-1:0] killers_o,
  output logic [NUM_CORES-1:0] racers_nxt_o
);

  cfl_action_t          act;
  logic [NUM_CORES-1:0] core_bit;
  logic [NUM_CORES-1:0] killers_nxt;

  assign act      = classify(loc_rd_i, loc_md_i, rem_wr_i);
  assign core_bit = NUM_CORES'(1) << core_i;

  assign racers_nxt_o = racers_o  | ((en_i && act.set_racer)  ? core_bit : '0);
  assign killers_nxt  = killers_o | ((en_i && act.set_killer) ? core_bit : '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      racers_o  <= '0;
      killers_o <= '0;
    end else begin
      racers_o  <= racers_nxt_o;
      killers_o <= killers_nxt;
    end
  end

endmodule

// File: rtl/tct_commit_seq.sv
module tct_commit_seq
  import tct_pkg::*;
#(
  parameter int NUM_CORES = 8,
  localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [NUM_CORES-1:0] load_vec_i,
  input  logic                 running_i,
  input  logic                 ack_valid_i,
  input  logic [CID_W-1:0]     ack_src_i,
  output logic                 abt_valid_o,
  output logic [CID_W-1:0]     abt_dst_o,
  output logic                 done_o
);

  logic [NUM_CORES-1:0] send_q;
  logic [NUM_CORES-1:0] wait_q;
  logic [NUM_CORES-1:0] sent_bit;
  logic [NUM_CORES-1:0] ack_bit;

  assign abt_valid_o = running_i && (send_q != '0);
  assign abt_dst_o   = CID_W'(lowest_index(32'(send_q)));
  assign done_o      = running_i && (send_q == '0) && (wait_q == '0);

  assign sent_bit = abt_valid_o ? (NUM_CORES'(1) << abt_dst_o) : '0;
  assign ack_bit  = ack_valid_i ? (NUM_CORES'(1) << ack_src_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_q <= '0;
      wait_q <= '0;
    end else if (load_i) begin
      send_q <= load_vec_i;
      wait_q <= load_vec_i;
    end else if (running_i) begin
      send_q <= send_q & ~sent_bit;
      wait_q <= wait_q & ~ack_bit;
    end
  end

endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker
  import tct_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int NUM_LINES = 16,
  parameter int CORE_ID   = 3,
  localparam int CID_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int LIDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_begin_i,
  input  logic                 tx_commit_i,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic [LIDX_W-1:0]    acc_line_i,
  input  logic                 cfl_valid_i,
  input  logic [CID_W-1:0]     cfl_core_i,
  input  logic                 cfl_write_i,
  input  logic [LIDX_W-1:0]    cfl_line_i,
  input  logic                 abt_valid_i,
  input  logic [CID_W-1:0]     abt_src_i,
  input  logic                 abt_ack_valid_i,
  input  logic [CID_W-1:0]     abt_ack_src_i,
  output logic                 abt_valid_o,
  output logic [CID_W-1:0]     abt_dst_o,
  output logic                 abt_ack_valid_o,
  output logic [CID_W-1:0]     abt_ack_dst_o,
  output logic                 ckpt_restore_o,
  output logic                 commit_done_o,
  output logic [NUM_CORES-1:0] racers_o,
  output logic [NUM_CORES-1:0] killers_o
);

  tx_state_e            state_q;
  logic                 in_active;
  logic                 in_commit;
  logic                 ev_abort_take;
  logic                 ev_begin;
  logic                 ev_commit;
  logic                 ev_done;
  logic                 ev_clear;
  logic                 ev_cfl;
  logic                 look_rd;
  logic                 look_md;
  logic [NUM_CORES-1:0] racers_nxt;

  assign in_active     = (state_q == ST_ACTIVE);
  assign in_commit     = (state_q == ST_COMMIT);
  assign ev_abort_take = abt_valid_i && in_active;
  assign ev_begin      = tx_begin_i && (state_q == ST_IDLE);
  assign ev_commit     = tx_commit_i && in_active && !abt_valid_i;
  assign ev_clear      = ev_begin || ev_done || ev_abort_take;
  assign ev_cfl        = cfl_valid_i && in_active && !abt_valid_i &&
                         (cfl_core_i != CID_W'(CORE_ID));

  tct_line_sets #(.NUM_LINES(NUM_LINES)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (ev_clear),
    .set_en_i   (acc_valid_i && in_active && !abt_valid_i),
    .set_write_i(acc_write_i),
    .set_line_i (acc_line_i),
    .look_line_i(cfl_line_i),
    .look_rd_o  (look_rd),
    .look_md_o  (look_md)
  );

  tct_conflict_vec #(.NUM_CORES(NUM_CORES)) u_vec (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (ev_clear),
    .en_i        (ev_cfl),
    .core_i      (cfl_core_i),
    .rem_wr_i    (cfl_write_i),
    .loc_rd_i    (look_rd),
    .loc_md_i    (look_md),
    .racers_o    (racers_o),
    .killers_o   (killers_o),
    .racers_nxt_o(racers_nxt)
  );

  tct_commit_seq #(.NUM_CORES(NUM_CORES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ev_commit),
    .load_vec_i (racers_nxt),
    .running_i  (in_commit),
    .ack_valid_i(abt_ack_valid_i),
    .ack_src_i  (abt_ack_src_i),
    .abt_valid_o(abt_valid_o),
    .abt_dst_o  (abt_dst_o),
    .done_o     (ev_done)
  );

  assign commit_done_o = ev_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (ev_abort_take) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (ev_begin)  state_q <= ST_ACTIVE;
        ST_ACTIVE: if (ev_commit) state_q <= ST_COMMIT;
        ST_COMMIT: if (ev_done)   state_q <= ST_IDLE;
        default:                  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abt_ack_valid_o <= 1'b0;
      abt_ack_dst_o   <= '0;
      ckpt_restore_o  <= 1'b0;
    end else begin
      abt_ack_valid_o <= abt_valid_i;
      abt_ack_dst_o   <= abt_src_i;
      ckpt_restore_o  <= ev_abort_take;
    end
  end

endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int NUM_CORES = 8,
  parameter int CORE_ID   = 3,
  localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 abt_valid_o,
  input logic [CID_W-1:0]     abt_dst_o,
  input logic                 abt_ack_valid_o,
  input logic                 ckpt_restore_o,
  input logic                 commit_done_o,
  input logic [NUM_CORES-1:0] racers_o,
  input logic [NUM_CORES-1:0] killers_o
);

  AST_ABORT_TARGETS_RACER: assert property (@(posedge clk) disable iff (!rst_n)
    abt_valid_o |-> racers_o[abt_dst_o]); // R6

  AST_ABORT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    abt_valid_o |=> (!abt_valid_o || (abt_dst_o > $past(abt_dst_o)))); // R6

  AST_DONE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done_o |-> !abt_valid_o); // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done_o |=> (racers_o == '0 && killers_o == '0)); // R11

  AST_RESTORE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore_o |-> abt_ack_valid_o); // R8

  AST_RESTORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_restore_o |-> (racers_o == '0 && killers_o == '0)); // R8

  AST_NEVER_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    !racers_o[CORE_ID] && !killers_o[CORE_ID]); // R10

endmodule

bind txn_conflict_tracker tct_checker #(.NUM_CORES(NUM_CORES), .CORE_ID(CORE_ID)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .abt_valid_o    (abt_valid_o),
  .abt_dst_o      (abt_dst_o),
  .abt_ack_valid_o(abt_ack_valid_o),
  .ckpt_restore_o (ckpt_restore_o),
  .commit_done_o  (commit_done_o),
  .racers_o       (racers_o),
  .killers_o      (killers_o)
);

// File: tb/test_txn_conflict_tracker.sv
module test_txn_conflict_tracker;
  localparam int NC = 8;
  localparam int NL = 16;
  localparam int ME = 3;

  logic clk = 0, rst_n = 0;
  logic tx_begin_i = 0, tx_commit_i = 0;
  logic acc_valid_i = 0, acc_write_i = 0;
  logic [3:0] acc_line_i = 0;
  logic cfl_valid_i = 0, cfl_write_i = 0;
  logic [2:0] cfl_core_i = 0;
  logic [3:0] cfl_line_i = 0;
  logic abt_valid_i = 0, abt_ack_valid_i = 0;
  logic [2:0] abt_src_i = 0, abt_ack_src_i = 0;
  logic abt_valid_o, abt_ack_valid_o, ckpt_restore_o, commit_done_o;
  logic [2:0] abt_dst_o, abt_ack_dst_o;
  logic [NC-1:0] racers_o, killers_o;

  txn_conflict_tracker #(.NUM_CORES(NC), .NUM_LINES(NL), .CORE_ID(ME)) i_txn_conflict_tracker (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_st = 0;            // 0 idle, 1 running, 2 committing
  bit m_rd[NL], m_md[NL];
  bit [NC-1:0] m_rac = 0, m_kil = 0;
  int m_q[$];
  bit m_wait[NC];
  bit m_ack = 0, m_rst = 0;
  int m_ackd = 0;

  function automatic int wait_cnt();
    int c = 0;
    for (int i = 0; i < NC; i++) if (m_wait[i]) c++;
    return c;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < NL; i++) begin m_rd[i] = 0; m_md[i] = 0; end
    m_rac = 0; m_kil = 0;
  endtask

  task automatic m_step();
    bit nack = abt_valid_i, nrst = 0;
    int nd = abt_src_i;
    bit done_now = (m_st == 2) && (m_q.size() == 0) && (wait_cnt() == 0);
    if (abt_valid_i && m_st == 1) begin
      nrst = 1; m_clear(); m_st = 0;
    end else if (m_st == 0) begin
      if (tx_begin_i) begin m_clear(); m_st = 1; end
    end else if (m_st == 1) begin
      if (cfl_valid_i && cfl_core_i != ME) begin
        if (m_md[cfl_line_i]) m_rac[cfl_core_i] = 1;
        if (cfl_write_i && (m_rd[cfl_line_i] || m_md[cfl_line_i])) m_kil[cfl_core_i] = 1;
      end
      if (acc_valid_i) begin
        if (acc_write_i) m_md[acc_line_i] = 1; else m_rd[acc_line_i] = 1;
      end
      if (tx_commit_i) begin
        m_q.delete();
        for (int i = 0; i < NC; i++) begin
          m_wait[i] = m_rac[i];
          if (m_rac[i]) m_q.push_back(i);
        end
        m_st = 2;
      end
    end else begin
      if (done_now) begin
        m_clear(); m_st = 0;
      end else begin
        if (abt_ack_valid_i) m_wait[abt_ack_src_i] = 0;
        if (m_q.size() > 0) void'(m_q.pop_front());
      end
    end
    m_ack = nack; m_ackd = nd; m_rst = nrst;
  endtask

  task automatic compare();
    bit ev = (m_st == 2) && (m_q.size() > 0);
    bit ed = (m_st == 2) && (m_q.size() == 0) && (wait_cnt() == 0);
    chk(abt_valid_o == ev, "R6 abort valid", abt_valid_o, ev);
    if (ev) chk(abt_dst_o == m_q[0], "R6 abort dst", abt_dst_o, m_q[0]);
    chk(abt_ack_valid_o == m_ack, "R8 ack valid", abt_ack_valid_o, m_ack);
    if (m_ack) chk(abt_ack_dst_o == m_ackd, "R8 ack dst", abt_ack_dst_o, m_ackd);
    chk(ckpt_restore_o == m_rst, "R8 restore", ckpt_restore_o, m_rst);
    chk(commit_done_o == ed, "R7 done", commit_done_o, ed);
    chk(racers_o == m_rac, "R3 racers", racers_o, m_rac);
    chk(killers_o == m_kil, "R4 killers", killers_o, m_kil);
  endtask

  task automatic cyc();
    @(posedge clk);
    m_step();
    @(negedge clk);
    compare();
    tx_begin_i = 0; tx_commit_i = 0; acc_valid_i = 0; cfl_valid_i = 0;
    abt_valid_i = 0; abt_ack_valid_i = 0;
  endtask

  task automatic acc(input bit w, input int l);
    acc_valid_i = 1; acc_write_i = w; acc_line_i = l[3:0]; cyc();
  endtask
  task automatic cfl(input int c, input bit w, input int l);
    cfl_valid_i = 1; cfl_core_i = c[2:0]; cfl_write_i = w; cfl_line_i = l[3:0]; cyc();
  endtask
  task automatic ack(input int c);
    abt_ack_valid_i = 1; abt_ack_src_i = c[2:0]; cyc();
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(!abt_valid_o && !commit_done_o && !ckpt_restore_o && racers_o == 0, "reset", racers_o, 0);

    // Scenario A: classification and ordered commit
    tx_begin_i = 1; cyc();
    acc(0, 2); acc(1, 5);
    cfl(1, 0, 2);
    chk(racers_o == 0 && killers_o == 0, "R2", {racers_o, killers_o}, 0);
    cfl(1, 1, 2);
    chk(killers_o == 8'h02, "R4", killers_o, 8'h02);
    cfl(6, 0, 5);
    chk(racers_o == 8'h40, "R3", racers_o, 8'h40);
    cfl(0, 1, 5);
    chk(racers_o == 8'h41 && killers_o == 8'h03, "R3", {racers_o, killers_o}, 16'h4103);
    cfl(2, 1, 9);
    chk(racers_o == 8'h41 && killers_o == 8'h03, "R5", {racers_o, killers_o}, 16'h4103);
    cfl(ME, 1, 5);
    chk(racers_o == 8'h41 && killers_o == 8'h03, "R10", {racers_o, killers_o}, 16'h4103);
    tx_commit_i = 1; cyc();
    chk(abt_valid_o && abt_dst_o == 0, "R6", abt_dst_o, 0);
    cyc();
    chk(abt_valid_o && abt_dst_o == 6 && racers_o == 8'h41, "R6", abt_dst_o, 6);
    cyc();
    chk(!abt_valid_o && !commit_done_o, "R7", commit_done_o, 0);
    ack(6);
    chk(!commit_done_o, "R7", commit_done_o, 0);
    ack(0);
    chk(commit_done_o, "R7", commit_done_o, 1);
    cyc();
    chk(racers_o == 0 && killers_o == 0 && !commit_done_o, "R11", {racers_o, killers_o}, 0);

    // Scenario B: empty racers
    tx_begin_i = 1; cyc();
    acc(0, 1);
    tx_commit_i = 1; cyc();
    chk(commit_done_o && !abt_valid_o, "R7", commit_done_o, 1);
    cyc();

    // Scenario C: abort while running, notification while idle
    tx_begin_i = 1; cyc();
    acc(1, 4);
    cfl(5, 0, 4);
    chk(racers_o == 8'h20, "R3", racers_o, 8'h20);
    abt_valid_i = 1; abt_src_i = 2; cyc();
    chk(ckpt_restore_o && abt_ack_valid_o && abt_ack_dst_o == 2, "R8", abt_ack_dst_o, 2);
    chk(racers_o == 0, "R11", racers_o, 0);
    cfl(5, 1, 4);
    chk(racers_o == 0 && killers_o == 0 && !ckpt_restore_o, "R10", {racers_o, killers_o}, 0);

    // Scenario D: abort during commit sequence
    tx_begin_i = 1; cyc();
    acc(1, 7);
    cfl(1, 0, 7);
    tx_commit_i = 1; cyc();
    chk(abt_valid_o && abt_dst_o == 1, "R6", abt_dst_o, 1);
    abt_valid_i = 1; abt_src_i = 4; cyc();
    chk(abt_ack_valid_o && abt_ack_dst_o == 4 && !ckpt_restore_o && !commit_done_o, "R9", ckpt_restore_o, 0);
    ack(1);
    chk(commit_done_o, "R9", commit_done_o, 1);
    cyc();

    // Scenario E: abort and commit together
    tx_begin_i = 1; cyc();
    acc(1, 3);
    cfl(2, 0, 3);
    tx_commit_i = 1; abt_valid_i = 1; abt_src_i = 2; cyc();
    chk(ckpt_restore_o && !abt_valid_o && !commit_done_o, "R12", ckpt_restore_o, 1);
    cyc();

    // Scenario F: notification in the commit cycle
    tx_begin_i = 1; cyc();
    acc(1, 0);
    tx_commit_i = 1; cfl_valid_i = 1; cfl_core_i = 7; cfl_write_i = 0; cfl_line_i = 0; cyc();
    chk(abt_valid_o && abt_dst_o == 7, "R12", abt_dst_o, 7);
    ack(7);
    chk(commit_done_o, "R12", commit_done_o, 1);
    cyc();

    // Commit outside a transaction
    tx_commit_i = 1; cyc();
    chk(!commit_done_o && !abt_valid_o, "R1", commit_done_o, 0);
    cyc();
    chk(!commit_done_o && !abt_valid_o, "R1", commit_done_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule